// File: doc/BRIEF.md
# E3 Overhead Bit Insertion Sequencer

This block sits on the terminal-equipment side of a serial overhead-insertion port of an E3 transmit framer. It runs on the overhead clock that the framer supplies, and it watches a frame-marker input that the framer raises once per frame. After each marker it counts the rising edges of the overhead clock. It then uses that count to decide which overhead bit the framer is expecting on the current cycle.

The window runs from count 30 to count 55. It covers two trail-trace bits, then the maintenance byte (its top two bits carry the far-end receive-failure and far-end block-error flags), the network-requirement byte and the general-communication byte. Software supplies the byte values and a 26-bit mask. For every armed position the block raises an insert strobe and puts the bit value on a serial data output. Both are driven from registers, so they hold steady for one full overhead-clock period.

The byte values and the mask are captured at the frame marker. A frame therefore always uses one consistent set of values, even when software rewrites the inputs partway through the frame.

Top module: `e3_ovh_inserter`

## Requirements
- R1: A rising overhead-clock edge at which the frame marker is sampled high sets the position count to 0. While the marker stays high, the count stays at 0. Each later edge adds one to the count.
- R2: The count stops at its all-ones value (63 by default) and stays there until the next marker. The insert strobe is never high at a count below 30 or above 55.
- R3: At count 30 the block offers trail-trace bit 1, and at count 31 it offers trail-trace bit 0 (`tr_bits[1]`, then `tr_bits[0]`).
- R4: Counts 32 to 39 offer `ma_byte` bits 7 down to 0, most significant first. Bit 7 is the far-end receive-failure flag and bit 6 is the far-end block-error flag.
- R5: Counts 40 to 47 offer `nr_byte` bits 7 down to 0. Counts 48 to 55 offer `gc_byte` bits 7 down to 0.
- R6: Mask bit p controls the position at count 30+p. When that bit is set, `ins_en` is 1 and `ins_data` carries the bit. When it is clear, `ins_en` is 0 and `ins_data` is 0.
- R7: `ins_en` and `ins_data` change only just after a rising overhead-clock edge. They then hold their values until the next rising edge.
- R8: Byte and mask inputs are captured only at an edge where the marker is sampled high. Changes made at any other time have no effect on the current frame.
- R9: While reset is asserted, and after it is released until the first marker arrives, `ins_en` and `ins_data` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ovh_clk | input | 1 | Overhead clock from the framer; all state moves on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_mark | input | 1 | Frame marker from the framer, sampled on each rising edge |
| tr_bits | input | 2 | Trail-trace bits 1 and 0 |
| ma_byte | input | 8 | Maintenance byte (bit 7 is the receive-failure flag, bit 6 is the block-error flag) |
| nr_byte | input | 8 | Network-requirement byte |
| gc_byte | input | 8 | General-communication byte |
| ins_mask | input | 26 | Per-position insert enables; bit p arms count 30+p |
| ins_en | output | 1 | Insert strobe for the current overhead position |
| ins_data | output | 1 | Overhead bit value for the current position |

## Verification
The bench plays the framer. It checks every window position against values it builds from the programmed bytes and the mask, which catches a wrong offset, a reversed bit order or a byte swapped with its neighbour. One frame runs past count 63; a counter that wraps instead of stopping would insert a second time. A frame with the marker held high for three edges would show a shifted schedule if the marker were treated as a one-shot event. A frame with inputs scrambled mid-window would show mixed values if the capture were not tied to the marker. A frame with the mask cleared would expose stray strobes or stray data. Every output is sampled twice per period, so an output that moved between edges is reported.

// File: rtl/e3_ovh_pkg.sv
// Shared constants and types for the E3 overhead insertion sequencer.
// Assumes the overhead window is fixed at counts 30..55 (26 positions).
package e3_ovh_pkg;
    localparam int FIRST_POS = 30;
    localparam int NUM_POS   = 26;
    localparam int LAST_POS  = FIRST_POS + NUM_POS - 1;
    localparam int IDX_W     = $clog2(NUM_POS);

    // Captured per-frame configuration.
    typedef struct packed {
        logic [1:0]         tr;
        logic [7:0]         ma;
        logic [7:0]         nr;
        logic [7:0]         gc;
        logic [NUM_POS-1:0] mask;
    } ovh_cfg_t;
endpackage

// File: rtl/e3_ovh_pos_counter.sv
// Position counter: counts overhead-clock edges since the frame marker
// was last sampled high. Assumes CNT_W is large enough to reach LAST_POS+1,
// so that the saturated value lies outside the overhead window.
module e3_ovh_pos_counter #(
    parameter int CNT_W = 6
) (
    input  logic             ovh_clk,
    input  logic             rst_n,
    input  logic             frame_mark,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Clear on marker, otherwise step forward and hold at the top value.
    always_ff @(posedge ovh_clk) begin
        if (!rst_n)
            cnt <= CNT_MAX;
        else if (frame_mark)
            cnt <= '0;
        else if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assert_clear_on_mark_R1: assert property (@(posedge ovh_clk) disable iff (!rst_n)
        frame_mark |=> (cnt == '0));

    assert_step_R1: assert property (@(posedge ovh_clk) disable iff (!rst_n)
        (!frame_mark && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));

    assert_saturate_R2: assert property (@(posedge ovh_clk) disable iff (!rst_n)
        (!frame_mark && cnt == CNT_MAX) |=> (cnt == CNT_MAX));
endmodule

// File: rtl/e3_ovh_shadow.sv
// Frame shadow register: captures the byte values and the mask at the frame
// marker, so that one frame never mixes old and new settings.
// Assumes software writes may arrive at any time relative to the frame.
module e3_ovh_shadow (
    input  logic                  ovh_clk,
    input  logic                  rst_n,
    input  logic                  frame_mark,
    input  e3_ovh_pkg::ovh_cfg_t  cfg_in,
    output e3_ovh_pkg::ovh_cfg_t  cfg_q
);
    // Load the live settings only on a sampled marker; reset disarms every position.
    always_ff @(posedge ovh_clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (frame_mark)
            cfg_q <= cfg_in;
    end

    assert_hold_midframe_R8: assert property (@(posedge ovh_clk) disable iff (!rst_n)
        !frame_mark |=> $stable(cfg_q));

    assert_load_on_mark_R8: assert property (@(posedge ovh_clk) disable iff (!rst_n)
        frame_mark |=> (cfg_q == $past(cfg_in)));
endmodule

// File: rtl/e3_ovh_bit_select.sv
// Bit selector: turns the position count into a window index and picks the
// matching overhead bit and mask bit from the captured frame settings.
// Assumes its inputs come from registers, so the outputs are stable between edges.
module e3_ovh_bit_select #(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0]      cnt,
    input  e3_ovh_pkg::ovh_cfg_t  cfg,
    output logic                  sel_en,
    output logic                  sel_data
);
    import e3_ovh_pkg::*;

    logic [NUM_POS-1:0] pos_bits;
    logic               in_win;
    logic [IDX_W-1:0]   idx;

    // Lay the bytes out in transmit order: TR 1..0, MA 7..0, NR 7..0, GC 7..0.
    for (genvar p = 0; p < NUM_POS; p++) begin : g_map
        if (p < 2) begin : g_tr
            assign pos_bits[p] = cfg.tr[1-p];
        end else if (p < 10) begin : g_ma
            assign pos_bits[p] = cfg.ma[9-p];
        end else if (p < 18) begin : g_nr
            assign pos_bits[p] = cfg.nr[17-p];
        end else begin : g_gc
            assign pos_bits[p] = cfg.gc[25-p];
        end
    end

    // Window decode and bit pick; positions outside the window stay quiet.
    always_comb begin
        in_win   = (cnt >= CNT_W'(FIRST_POS)) && (cnt <= CNT_W'(LAST_POS));
        idx      = IDX_W'(cnt - CNT_W'(FIRST_POS));
        sel_en   = 1'b0;
        sel_data = 1'b0;
        if (in_win) begin
            sel_en   = cfg.mask[idx];
            sel_data = cfg.mask[idx] & pos_bits[idx];
        end
    end
endmodule

// File: rtl/e3_ovh_inserter.sv
// Top of the E3 overhead insertion sequencer. Counts overhead-clock edges
// after the frame marker and drives the insert strobe and serial data for
// every armed overhead position in the 30..55 window.
// Assumes ovh_clk is the framer's overhead clock and frame_mark is synchronous to it.
module e3_ovh_inserter #(
    parameter int CNT_W = 6
) (
    input  logic        ovh_clk,
    input  logic        rst_n,
    input  logic        frame_mark,
    input  logic [1:0]  tr_bits,
    input  logic [7:0]  ma_byte,
    input  logic [7:0]  nr_byte,
    input  logic [7:0]  gc_byte,
    input  logic [25:0] ins_mask,
    output logic        ins_en,
    output logic        ins_data
);
    import e3_ovh_pkg::*;

    logic [CNT_W-1:0] cnt;
    ovh_cfg_t         cfg_live;
    ovh_cfg_t         cfg_q;

    // Gather the live inputs into one settings word.
    always_comb begin
        cfg_live.tr   = tr_bits;
        cfg_live.ma   = ma_byte;
        cfg_live.nr   = nr_byte;
        cfg_live.gc   = gc_byte;
        cfg_live.mask = ins_mask;
    end

    e3_ovh_pos_counter #(.CNT_W(CNT_W)) u_cnt (
        .ovh_clk    (ovh_clk),
        .rst_n      (rst_n),
        .frame_mark (frame_mark),
        .cnt        (cnt)
    );

    e3_ovh_shadow u_shadow (
        .ovh_clk    (ovh_clk),
        .rst_n      (rst_n),
        .frame_mark (frame_mark),
        .cfg_in     (cfg_live),
        .cfg_q      (cfg_q)
    );

    e3_ovh_bit_select #(.CNT_W(CNT_W)) u_sel (
        .cnt      (cnt),
        .cfg      (cfg_q),
        .sel_en   (ins_en),
        .sel_data (ins_data)
    );

    assert_window_only_R2: assert property (@(posedge ovh_clk) disable iff (!rst_n)
        ins_en |-> (cnt >= CNT_W'(FIRST_POS) && cnt <= CNT_W'(LAST_POS)));

    assert_quiet_data_R6: assert property (@(posedge ovh_clk) disable iff (!rst_n)
        !ins_en |-> !ins_data);

    assert_reset_quiet_R9: assert property (@(posedge ovh_clk)
        !rst_n |=> (!ins_en && !ins_data));
endmodule

// File: tb/e3_ovh_inserter_test.sv
// Scoreboard bench: the driver plays the framer and queues the expected
// strobe and data for every period; the monitor pops and compares twice per period.
module e3_ovh_inserter_test;
    import e3_ovh_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_mark = 1'b0;
    logic [1:0]  tr_bits = '0;
    logic [7:0]  ma_byte = '0;
    logic [7:0]  nr_byte = '0;
    logic [7:0]  gc_byte = '0;
    logic [25:0] ins_mask = '0;
    logic        ins_en;
    logic        ins_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        bit    en;
        bit    data;
        int    cnt;
        string req;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    e3_ovh_inserter uut (
        .ovh_clk(clk), .rst_n(rst_n), .frame_mark(frame_mark),
        .tr_bits(tr_bits), .ma_byte(ma_byte), .nr_byte(nr_byte),
        .gc_byte(gc_byte), .ins_mask(ins_mask),
        .ins_en(ins_en), .ins_data(ins_data)
    );

    function automatic bit pick_bit(ovh_cfg_t c, int p);
        if (p < 2)  return c.tr[1-p];
        if (p < 10) return c.ma[9-p];
        if (p < 18) return c.nr[17-p];
        return c.gc[25-p];
    endfunction

    function automatic string tag_of(int c, bit armed);
        if (c < 30 || c > 55) return "R2";
        if (!armed)           return "R6";
        if (c < 32)           return "R3";
        if (c < 40)           return "R4";
        return "R5";
    endfunction

    task automatic check(string req, int cnt, bit a_en, bit a_d, bit e_en, bit e_d);
        checks++;
        if (a_en !== e_en || a_d !== e_d) begin
            failures++;
            $display("FAIL %s count=%0d actual en=%0b data=%0b expected en=%0b data=%0b",
                     req, cnt, a_en, a_d, e_en, e_d);
        end
    endtask

    task automatic apply(ovh_cfg_t c);
        tr_bits = c.tr; ma_byte = c.ma; nr_byte = c.nr; gc_byte = c.gc; ins_mask = c.mask;
    endtask

    // Driver: one frame, marker high for 'hold' edges; optional mid-frame scramble (R8).
    task automatic run_frame(ovh_cfg_t c, int hold, int len, bit scramble);
        apply(c);
        frame_mark = 1'b1;
        for (int k = 0; k < len; k++) begin
            exp_t e;
            int   cv;
            bit   armed;
            cv = (k < hold) ? 0 : k - hold + 1;
            if (cv > 63) cv = 63;
            armed = (cv >= 30 && cv <= 55) ? c.mask[cv-30] : 1'b0;
            e.cnt  = cv;
            e.en   = armed;
            e.data = armed ? pick_bit(c, cv - 30) : 1'b0;
            e.req  = scramble ? "R8" : (k < hold ? "R1" : tag_of(cv, armed));
            sb.push_back(e);
        end
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (i >= hold) frame_mark = 1'b0;
            if (scramble && i == 5) apply(~c);
        end
    endtask

    // Monitor: pop one expectation per period, sample early and late (R7).
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                bit   en1, d1;
                e = sb.pop_front();
                en1 = ins_en; d1 = ins_data;
                check(e.req, e.cnt, en1, d1, e.en, e.data);
                #10;
                check("R7", e.cnt, ins_en, ins_data, en1, d1);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #2000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired with %0d expectations pending", sb.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        ovh_cfg_t c;
        // R9: outputs quiet in reset.
        repeat (3) begin
            @(negedge clk);
            check("R9", -1, ins_en, ins_data, 1'b0, 1'b0);
        end
        // R9: still quiet after release, before any marker, even with inputs armed.
        c = '{tr: 2'b11, ma: 8'hFF, nr: 8'hFF, gc: 8'hFF, mask: '1};
        apply(c);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) sb.push_back('{en: 1'b0, data: 1'b0, cnt: 63, req: "R9"});
        repeat (6) @(negedge clk);

        // Full mask, two data patterns (R3, R4, R5).
        c = '{tr: 2'b10, ma: 8'hC5, nr: 8'h3A, gc: 8'h96, mask: '1};
        run_frame(c, 1, 60, 1'b0);
        c = '{tr: 2'b01, ma: 8'h5C, nr: 8'hE1, gc: 8'h0F, mask: '1};
        run_frame(c, 1, 56, 1'b0);
        // Partial mask (R6).
        c = '{tr: 2'b11, ma: 8'hFF, nr: 8'h00, gc: 8'hA5, mask: 26'h2A5_3C96};
        run_frame(c, 1, 56, 1'b0);
        // Mask cleared with busy data (R6).
        c = '{tr: 2'b11, ma: 8'hFF, nr: 8'hFF, gc: 8'hFF, mask: '0};
        run_frame(c, 1, 56, 1'b0);
        // Marker held high for three edges (R1).
        c = '{tr: 2'b10, ma: 8'h81, nr: 8'h7E, gc: 8'h33, mask: '1};
        run_frame(c, 3, 60, 1'b0);
        // Settings rewritten mid-frame (R8), then the next frame picks up new values.
        c = '{tr: 2'b01, ma: 8'h6B, nr: 8'h92, gc: 8'hD4, mask: 26'h3FF_F0FF};
        run_frame(c, 1, 58, 1'b1);
        c = '{tr: 2'b10, ma: 8'h94, nr: 8'h6D, gc: 8'h2B, mask: '1};
        run_frame(c, 1, 56, 1'b0);
        // Marker cuts a frame short inside the window (R1).
        c = '{tr: 2'b11, ma: 8'hF0, nr: 8'h0F, gc: 8'hCC, mask: '1};
        run_frame(c, 1, 40, 1'b0);
        // Long frame past the counter top value (R2).
        c = '{tr: 2'b11, ma: 8'hFF, nr: 8'hFF, gc: 8'hFF, mask: '1};
        run_frame(c, 1, 100, 1'b0);

        wait (sb.size() == 0);
        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule